// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns edges on seven asynchronous general-purpose inputs into CPU interrupts. Each input is brought into the clock domain by a two-stage synchronizer. A rising or falling transition is found by comparing the synchronized level with its value one cycle earlier. Software picks, per pin and per edge direction, which transitions are recorded. A recorded transition stays in a sticky pending bit until software writes a one to the matching position of a write-one-to-clear register.

The request line is raised while any recorded event is also enabled. Alongside it the block reports a vector number: a programmable base plus the index of the lowest-numbered pin that has an enabled pending event. Software reaches four word registers through a plain synchronous bus. Address bits [3:2] select the register: 0 for enables, 1 for clear, 2 for pending, 3 for vector base. Writes are taken on the clock edge and read data is combinational. The enable, clear and pending registers share one layout: bit n holds the rising event of pin n and bit n+8 holds the falling event. Every other bit reads as zero.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the enable, pending and vector-base registers all read 0, `irq_o` is 0 and `vec_o` is 0.
- R2: With enable bit n set, a rising edge on pin n sets pending bit n. The bit is visible after the third rising clock edge following the input change.
- R3: With enable bit n+8 set, a falling edge on pin n sets pending bit n+8, with the same latency as R2.
- R4: An edge whose own enable bit is 0 records nothing, even when the opposite edge of the same pin is enabled.
- R5: Writing the clear register (word 1) clears each pending bit whose position holds a 1. Positions that hold 0 are left unchanged. The clear register reads back as 0.
- R6: If a new edge and a clear for the same pending bit land in the same cycle, the bit ends up set.
- R7: `irq_o` is the OR of all pending bits whose enable bit is set. Clearing an enable bit masks the request, but the pending bit stays readable; setting the enable bit again raises the request again.
- R8: `vec_o` equals the vector base plus the index (0 to 6) of the lowest pin with an enabled pending event, on either edge. The sum wraps modulo 256. With no enabled pending event, `vec_o` equals the base.
- R9: The vector-base register (word 3) holds 8 bits and reads back as written.
- R10: The enable register (word 0) reads back the written value in bits 6:0 and 14:8. Bits 7 and 15 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_we | input | 1 | Write strobe, taken on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pins_in | input | 7 | Asynchronous pin inputs |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Reported vector number |

## Verification
The assertions assume that reset is held at time zero, so the history they compare starts from the all-zero state. They also assume that pins are low, or steady, when reset is released, so the synchronizer does not report a spurious edge. The bench drives every pin change and bus write on the falling clock edge and keeps pins low through reset. It lets each pin change settle for three rising clock edges before reading the pending state. It times the one combined edge-and-clear case so that the write lands on exactly the cycle in which the synchronized edge is recorded.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS = 7,
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int VW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NPINS-1:0] pins_in,
  output logic          irq_o,
  output logic [VW-1:0] vec_o
);
  localparam int FOFS = 8;
  localparam int EV   = 2 * NPINS;
  localparam logic [1:0] W_EN = 2'd0, W_CLR = 2'd1, W_PEND = 2'd2, W_BASE = 2'd3;

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [EV-1:0]    en_q, pend_q, hit, clr_mask, live;
  logic [VW-1:0]    base_q, idx;
  logic [1:0]       word;

  assign word = bus_addr[3:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pins_in;
      sync2 <= sync1;
      prev  <= sync2;
    end

  assign hit = {~sync2 & prev, sync2 & ~prev};

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NPINS; i++) begin
      clr_mask[i]         = bus_wdata[i];
      clr_mask[NPINS + i] = bus_wdata[FOFS + i];
    end
    if (!(bus_we && word == W_CLR)) clr_mask = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      base_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | (hit & en_q);
      if (bus_we && word == W_EN)
        for (int i = 0; i < NPINS; i++) begin
          en_q[i]         <= bus_wdata[i];
          en_q[NPINS + i] <= bus_wdata[FOFS + i];
        end
      if (bus_we && word == W_BASE) base_q <= bus_wdata[VW-1:0];
    end

  assign live  = pend_q & en_q;
  assign irq_o = |live;

  always_comb begin
    idx = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (live[i] || live[NPINS + i]) idx = VW'(i);
  end

  assign vec_o = base_q + idx;

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_EN:
        for (int i = 0; i < NPINS; i++) begin
          bus_rdata[i]        = en_q[i];
          bus_rdata[FOFS + i] = en_q[NPINS + i];
        end
      W_PEND:
        for (int i = 0; i < NPINS; i++) begin
          bus_rdata[i]        = pend_q[i];
          bus_rdata[FOFS + i] = pend_q[NPINS + i];
        end
      W_BASE: bus_rdata[VW-1:0] = base_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module gpio_edge_irq_chk #(
  parameter int NPINS = 7,
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int VW    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [DW-1:0]   bus_wdata,
  input logic            irq_o,
  input logic [VW-1:0]   vec_o,
  input logic [VW-1:0]   base_q,
  input logic [2*NPINS-1:0] en_q,
  input logic [2*NPINS-1:0] pend_q,
  input logic [2*NPINS-1:0] hit
);
  localparam int EV = 2 * NPINS;
  logic [EV-1:0] wmask;
  logic          clr_wr;
  logic [VW-1:0] off;

  assign clr_wr = bus_we && bus_addr[3:2] == 2'd1;
  assign off    = vec_o - base_q;
  always_comb begin
    wmask = '0;
    for (int i = 0; i < NPINS; i++) begin
      wmask[i]         = bus_wdata[i];
      wmask[NPINS + i] = bus_wdata[8 + i];
    end
  end

  assert_set_only_on_enabled_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~($past(hit) & $past(en_q))) == '0);

  assert_ones_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_wr) |-> (pend_q & $past(wmask) & ~$past(hit)) == '0);

  assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_wr) |-> ($past(pend_q) & ~pend_q) == '0);

  assert_vector_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> off < VW'(NPINS));

  assert_idle_vector_is_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> vec_o == base_q);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS), .AW(AW), .DW(DW), .VW(VW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .vec_o(vec_o), .base_q(base_q), .en_q(en_q), .pend_q(pend_q), .hit(hit)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [6:0]  pins_in = 0;
  logic        irq_o;
  logic [7:0]  vec_o;
  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in), .irq_o(irq_o), .vec_o(vec_o));

  initial forever begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.kind == 0 ? bus_rdata : it.kind == 1 ? {31'b0, irq_o} : {24'b0, vec_o};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic expect_out(input int k, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = k; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic pin(input int n, input logic v);
    @(negedge clk);
    pins_in[n] = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    expect_reg(4'h0, 0, "R1 enable");
    expect_reg(4'h8, 0, "R1 pending");
    expect_reg(4'hC, 0, "R1 base");
    expect_out(1, 0, "R1 irq");
    expect_out(2, 0, "R1 vec");

    wr(4'h0, 32'hFFFF_FFFF);
    expect_reg(4'h0, 32'h0000_7F7F, "R10 enable mask");
    wr(4'h0, 32'h0000_0201);
    expect_reg(4'h0, 32'h0000_0201, "R10 enable readback");

    pin(0, 1);
    expect_reg(4'h8, 32'h1, "R2 rise pin0");
    expect_out(1, 1, "R7 irq raised");
    expect_out(2, 0, "R8 vec pin0");

    wr(4'hC, 32'h0000_1240);
    expect_reg(4'hC, 32'h40, "R9 base");
    expect_out(2, 32'h40, "R8 vec base+0");

    pin(1, 1);
    expect_reg(4'h8, 32'h1, "R4 rise pin1 disabled");
    pin(1, 0);
    expect_reg(4'h8, 32'h201, "R3 fall pin1");
    expect_out(2, 32'h40, "R8 lowest wins");
    pin(0, 0);
    expect_reg(4'h8, 32'h201, "R4 fall pin0 disabled");

    wr(4'h4, 32'h0000_0001);
    expect_reg(4'h8, 32'h200, "R5 clear bit0");
    expect_reg(4'h4, 32'h0, "R5 clear reads zero");
    expect_out(2, 32'h41, "R8 vec pin1");
    wr(4'h4, 32'h0);
    expect_reg(4'h8, 32'h200, "R5 zero write no effect");

    wr(4'h0, 32'h0000_0001);
    expect_out(1, 0, "R7 masked");
    expect_reg(4'h8, 32'h200, "R7 pending kept");
    expect_out(2, 32'h40, "R8 idle vec base");
    wr(4'h0, 32'h0000_0201);
    expect_out(1, 1, "R7 unmasked");

    @(negedge clk) pins_in[0] = 1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = 4'h4; bus_wdata = 32'h1; bus_we = 1;
    @(negedge clk) bus_we = 0;
    expect_reg(4'h8, 32'h201, "R6 edge beats clear");

    wr(4'h4, 32'hFFFF);
    expect_reg(4'h8, 32'h0, "R5 clear all");
    expect_out(1, 0, "R7 irq low");

    wr(4'h0, 32'h0000_7F00);
    pin(6, 1);
    expect_reg(4'h8, 32'h0, "R4 rise pin6 disabled");
    pin(6, 0);
    expect_reg(4'h8, 32'h4000, "R3 fall pin6");
    expect_out(2, 32'h46, "R8 vec pin6");
    pin(0, 0);
    expect_reg(4'h8, 32'h4100, "R3 fall pin0");
    expect_out(2, 32'h40, "R8 vec pin0 fall");
    wr(4'hC, 32'hFE);
    expect_out(2, 32'hFE, "R8 base FE");
    wr(4'h4, 32'h0100);
    expect_out(2, 32'h04, "R8 wrap");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule